// File: doc/BRIEF.md
# Striped Multi-Pass Reservation Chain

This block lets several independent requesters share one fixed-latency processing pipeline. Each operation has to go through that pipeline several times. The block has NPORTS source ports and NPORTS destination ports. Between them sit NPORTS×NPASS holding slots, organised as NPASS groups of NPORTS slots each.

An operand accepted on source port k lands in slot k of group 0. When a slot is sent to the pipeline, it is tagged with its own slot index. The returning result is steered by that tag:

- A result from slot j goes into slot j+NPORTS, one group further down the same stripe.
- A result from a slot in the last group goes to destination port k.

A stripe therefore runs k → k+N → k+2N → … → destination k. The slot index doubles as the pass counter.

The pipeline is external and is fed through a single issue port. It always accepts an item and returns each item a fixed number of cycles later on a single return port. The block issues at most one item per cycle. A slot may issue only when the place its result will land is empty and not already promised to another item. This means returns never need a ready signal. When several slots could issue, the deepest group wins, and within a group the lowest port wins. Partly processed work therefore drains before fresh operands enter.

Top module: `rsv_chain`

## Requirements
- R1: While reset is held and on the first cycle after it, every srcReady is 1, every dstValid is 0 and issueValid is 0.
- R2: srcReady[k] is 1 exactly when slot k of group 0 is empty. A handshake on port k stores srcData lane k (bits k·DATA_W upward) into that slot, and srcReady[k] is 0 on the next cycle.
- R3: When issueValid is 1, issueTag is the index of the issuing slot, in the range 0 to NPORTS·NPASS−1, and issueData is the value that slot holds.
- R4: A return with tag j, where j < (NPASS−1)·NPORTS, stores retData into slot j+NPORTS. That value is the issueData later seen with tag j+NPORTS.
- R5: A return with tag (NPASS−1)·NPORTS+k makes dstValid[k] rise on the next cycle, with retData on dstData lane k. The value stays valid and stable until a cycle with dstReady[k] set.
- R6: A slot issues only if its successor (the next-group slot, or destination register k for the last group) is empty and not awaiting a return. With every destination stalled, issue stops completely.
- R7: Among the slots that may issue, the winner is the one in the highest group, and within that group the one with the lowest port number.
- R8: issueValid is 1 in every cycle in which at least one slot may issue, at most one item issues per cycle, and the issuing slot is empty on the next cycle.
- R9: Destination port k delivers exactly the operands accepted on source port k, in acceptance order, each after NPASS passes through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcValid | input | NPORTS | Operand offered on each source port |
| srcReady | output | NPORTS | Source port may hand over an operand |
| srcData | input | NPORTS·DATA_W | Operands, lane k for port k |
| dstValid | output | NPORTS | Result waiting on each destination port |
| dstReady | input | NPORTS | Consumer takes the result on port k |
| dstData | output | NPORTS·DATA_W | Results, lane k for port k |
| issueValid | output | 1 | An item is sent to the pipeline this cycle |
| issueTag | output | TAG_W | Slot index travelling with the item |
| issueData | output | DATA_W | Operand sent to the pipeline |
| retValid | input | 1 | Pipeline returns an item this cycle |
| retTag | input | TAG_W | Slot index that came back with the item |
| retData | input | DATA_W | Processed value |

## Verification
The bench keeps a behavioural model of slot occupancy and compares the issue choice every cycle. A design with the priority reversed, or one that favours new work, would show a different issueTag as soon as two groups compete. A long phase with every destination stalled must end with the chain completely full and the issue port idle. A design that lets a slot issue into an occupied or reserved successor would keep issuing there, and would overwrite a held value. Per-port scoreboards check that results come back on the same stripe in source order. An off-by-one in the tag steering (j+N) would put results on the wrong port, or give them too few or too many passes.

// File: rtl/rsv_chain_pkg.sv
package rsv_chain_pkg;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_FULL = 2'd2
  } slotState_e;

  localparam int IDX_MAX_W = 8;

  typedef struct packed {
    logic                 issueFire;
    logic [IDX_MAX_W-1:0] issueIdx;
    logic                 retFire;
    logic [IDX_MAX_W-1:0] retIdx;
  } rsvStrobe_t;

endpackage

// File: rtl/rsv_chain_ctrl.sv
module rsv_chain_ctrl
  import rsv_chain_pkg::*;
#(
  parameter  int NPORTS = 4,
  parameter  int NPASS  = 3,
  localparam int SLOTS  = NPORTS * NPASS,
  localparam int CELLS  = SLOTS + NPORTS,
  localparam int TAG_W  = $clog2(SLOTS),
  localparam int CELL_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] srcValid,
  output logic [NPORTS-1:0] srcReady,
  output logic [NPORTS-1:0] dstValid,
  input  logic [NPORTS-1:0] dstReady,
  input  logic              retValid,
  input  logic [TAG_W-1:0]  retTag,
  output logic [NPORTS-1:0] loadMask,
  output rsvStrobe_t        strobe
);

  // cells 0..SLOTS-1 are holding slots, SLOTS..CELLS-1 are destination registers
  slotState_e cellSt [CELLS];

  logic [SLOTS-1:0]  eligible;
  logic              found;
  logic [CELL_W-1:0] pickIdx;
  logic [CELL_W-1:0] pickCell;
  logic [CELL_W-1:0] retCell;

  always_comb begin
    for (int j = 0; j < SLOTS; j++) begin
      eligible[j] = (cellSt[j] == SLOT_FULL) && (cellSt[j+NPORTS] == SLOT_FREE);
    end
  end

  // deepest group first, lowest port inside a group: later hits overwrite earlier ones
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int g = 0; g < NPASS; g++) begin
      for (int k = NPORTS - 1; k >= 0; k--) begin
        if (eligible[g*NPORTS+k]) begin
          found   = 1'b1;
          pickIdx = CELL_W'(g * NPORTS + k);
        end
      end
    end
  end

  assign pickCell = pickIdx + CELL_W'(NPORTS);
  assign retCell  = CELL_W'(retTag) + CELL_W'(NPORTS);

  always_comb begin
    for (int k = 0; k < NPORTS; k++) begin
      srcReady[k] = (cellSt[k] == SLOT_FREE);
      loadMask[k] = srcValid[k] && (cellSt[k] == SLOT_FREE);
      dstValid[k] = (cellSt[SLOTS+k] == SLOT_FULL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < CELLS; c++) cellSt[c] <= SLOT_FREE;
    end else begin
      for (int k = 0; k < NPORTS; k++) begin
        if (loadMask[k]) cellSt[k] <= SLOT_FULL;
        if (dstValid[k] && dstReady[k]) cellSt[SLOTS+k] <= SLOT_FREE;
      end
      if (found) begin
        cellSt[pickIdx]  <= SLOT_FREE;
        cellSt[pickCell] <= SLOT_PEND;
      end
      if (retValid) cellSt[retCell] <= SLOT_FULL;
    end
  end

  assign strobe.issueFire = found;
  assign strobe.issueIdx  = IDX_MAX_W'(pickIdx);
  assign strobe.retFire   = retValid;
  assign strobe.retIdx    = IDX_MAX_W'(retTag);

  // R2: a taken operand occupies its group-0 slot on the next cycle
  for (genvar k = 0; k < NPORTS; k++) begin : g_srcChk
    p_src_take_r2: assert property (@(posedge clk) disable iff (rst)
      srcValid[k] && srcReady[k] |=> !srcReady[k]);
  end

  // R6: the successor of an issuing slot is reserved on the next cycle
  p_issue_reserve_r6: assert property (@(posedge clk) disable iff (rst)
    found |=> cellSt[$past(pickCell)] == SLOT_PEND);

  // R8: the issuing slot is released on the next cycle
  p_issue_clear_r8: assert property (@(posedge clk) disable iff (rst)
    found |=> cellSt[$past(pickIdx)] == SLOT_FREE);

  // R4: a return only lands in a slot that was reserved for it
  p_ret_pend_r4: assert property (@(posedge clk) disable iff (rst)
    retValid |-> cellSt[retCell] == SLOT_PEND);

endmodule

// File: rtl/rsv_chain_data.sv
module rsv_chain_data
  import rsv_chain_pkg::*;
#(
  parameter  int NPORTS = 4,
  parameter  int NPASS  = 3,
  parameter  int DATA_W = 16,
  localparam int SLOTS  = NPORTS * NPASS,
  localparam int CELLS  = SLOTS + NPORTS,
  localparam int CELL_W = $clog2(CELLS)
) (
  input  logic                     clk,
  input  logic [NPORTS-1:0]        loadMask,
  input  logic [NPORTS*DATA_W-1:0] srcData,
  input  rsvStrobe_t               strobe,
  input  logic [DATA_W-1:0]        retData,
  output logic [DATA_W-1:0]        issueData,
  output logic [NPORTS*DATA_W-1:0] dstData
);

  logic [DATA_W-1:0] cellData [CELLS];
  logic [CELL_W-1:0] retCell;
  logic [CELL_W-1:0] issueCell;

  assign issueCell = strobe.issueIdx[CELL_W-1:0];
  assign retCell   = strobe.retIdx[CELL_W-1:0] + CELL_W'(NPORTS);

  if (CELL_W < IDX_MAX_W) begin : g_unusedIdx
    logic unusedIdx;
    assign unusedIdx = ^{strobe.issueIdx[IDX_MAX_W-1:CELL_W], strobe.retIdx[IDX_MAX_W-1:CELL_W]};
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NPORTS; k++) begin
      if (loadMask[k]) cellData[k] <= srcData[k*DATA_W +: DATA_W];
    end
    if (strobe.retFire) cellData[retCell] <= retData;
  end

  assign issueData = strobe.issueFire ? cellData[issueCell] : '0;

  always_comb begin
    for (int k = 0; k < NPORTS; k++) begin
      dstData[k*DATA_W +: DATA_W] = cellData[SLOTS+k];
    end
  end

endmodule

// File: rtl/rsv_chain.sv
module rsv_chain
  import rsv_chain_pkg::*;
#(
  parameter  int NPORTS = 4,
  parameter  int NPASS  = 3,
  parameter  int DATA_W = 16,
  localparam int TAG_W  = $clog2(NPORTS * NPASS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        srcValid,
  output logic [NPORTS-1:0]        srcReady,
  input  logic [NPORTS*DATA_W-1:0] srcData,
  output logic [NPORTS-1:0]        dstValid,
  input  logic [NPORTS-1:0]        dstReady,
  output logic [NPORTS*DATA_W-1:0] dstData,
  output logic                     issueValid,
  output logic [TAG_W-1:0]         issueTag,
  output logic [DATA_W-1:0]        issueData,
  input  logic                     retValid,
  input  logic [TAG_W-1:0]         retTag,
  input  logic [DATA_W-1:0]        retData
);

  rsvStrobe_t        strobe;
  logic [NPORTS-1:0] loadMask;

  rsv_chain_ctrl #(.NPORTS(NPORTS), .NPASS(NPASS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .srcValid (srcValid),
    .srcReady (srcReady),
    .dstValid (dstValid),
    .dstReady (dstReady),
    .retValid (retValid),
    .retTag   (retTag),
    .loadMask (loadMask),
    .strobe   (strobe)
  );

  rsv_chain_data #(.NPORTS(NPORTS), .NPASS(NPASS), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .loadMask  (loadMask),
    .srcData   (srcData),
    .strobe    (strobe),
    .retData   (retData),
    .issueData (issueData),
    .dstData   (dstData)
  );

  assign issueValid = strobe.issueFire;
  assign issueTag   = strobe.issueIdx[TAG_W-1:0];

  // R5: a waiting result holds still until the consumer takes it
  for (genvar k = 0; k < NPORTS; k++) begin : g_dstChk
    p_dst_hold_r5: assert property (@(posedge clk) disable iff (rst)
      dstValid[k] && !dstReady[k] |=> dstValid[k] && $stable(dstData[k*DATA_W +: DATA_W]));
  end

endmodule

// File: tb/tb_rsv_chain.sv
module tb_rsv_chain;

  localparam int NP    = 4;
  localparam int NPS   = 3;
  localparam int W     = 16;
  localparam int LAT   = 3;
  localparam int SLOTS = NP * NPS;
  localparam int CELLS = SLOTS + NP;
  localparam int TW    = $clog2(SLOTS);

  logic              clk = 1'b0;
  logic              rst;
  logic [NP-1:0]     srcValid;
  logic [NP-1:0]     srcReady;
  logic [NP*W-1:0]   srcData;
  logic [NP-1:0]     dstValid;
  logic [NP-1:0]     dstReady;
  logic [NP*W-1:0]   dstData;
  logic              issueValid;
  logic [TW-1:0]     issueTag;
  logic [W-1:0]      issueData;
  logic              retValid;
  logic [TW-1:0]     retTag;
  logic [W-1:0]      retData;

  always #5 clk = ~clk;

  rsv_chain #(.NPORTS(NP), .NPASS(NPS), .DATA_W(W)) dut (
    .clk(clk), .rst(rst),
    .srcValid(srcValid), .srcReady(srcReady), .srcData(srcData),
    .dstValid(dstValid), .dstReady(dstReady), .dstData(dstData),
    .issueValid(issueValid), .issueTag(issueTag), .issueData(issueData),
    .retValid(retValid), .retTag(retTag), .retData(retData)
  );

  typedef struct packed { int due; int tag; int data; } pipeItem_t;

  int        compared   = 0;
  int        mismatched = 0;
  int        cyc        = 0;
  bit        done       = 1'b0;
  int        occ [CELLS];   // 0 empty, 1 awaiting return, 2 holding
  int        val [CELLS];
  int        sentQ [NP][$];
  pipeItem_t pipeQ [$];

  function automatic int passFn(int d);
    return (d * 5 + 3) & 16'hFFFF;
  endfunction

  function automatic int passAll(int d);
    int x = d;
    for (int i = 0; i < NPS; i++) x = passFn(x);
    return x;
  endfunction

  task automatic checkEq(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // called at a falling edge: compare, drive inputs, advance model, wait one cycle
  task automatic step(input logic [NP-1:0] sv, input logic [NP-1:0] dr);
    int  nOcc [CELLS];
    int  w = 0;
    bit  found = 1'b0;
    pipeItem_t it;
    for (int k = 0; k < NP; k++) begin
      checkEq("R2", "srcReady", int'(srcReady[k]), int'(occ[k] == 0));
      checkEq("R5", "dstValid", int'(dstValid[k]), int'(occ[SLOTS+k] == 2));
      if (occ[SLOTS+k] == 2) checkEq("R5", "dstData", int'(dstData[k*W +: W]), val[SLOTS+k]);
    end
    for (int g = 0; g < NPS; g++)
      for (int k = NP - 1; k >= 0; k--)
        if (occ[g*NP+k] == 2 && occ[g*NP+k+NP] == 0) begin found = 1'b1; w = g*NP+k; end
    checkEq("R8", "issueValid", int'(issueValid), int'(found));
    if (found && issueValid) begin
      checkEq("R7", "issueTag", int'(issueTag), w);
      checkEq("R3/R4", "issueData", int'(issueData), val[w]);
    end
    // environment: the shared pipeline, fed from the actual issue port
    if (issueValid) begin
      it.due = cyc + LAT; it.tag = int'(issueTag); it.data = passFn(int'(issueData));
      pipeQ.push_back(it);
    end
    retValid = 1'b0; retTag = '0; retData = '0;
    if (pipeQ.size() > 0 && pipeQ[0].due == cyc) begin
      it = pipeQ.pop_front();
      retValid = 1'b1; retTag = TW'(it.tag); retData = W'(it.data);
    end
    srcValid = sv;
    for (int k = 0; k < NP; k++) srcData[k*W +: W] = W'($urandom);
    dstReady = dr;
    // model next state
    nOcc = occ;
    for (int k = 0; k < NP; k++) begin
      if (sv[k] && occ[k] == 0) begin
        nOcc[k] = 2;
        val[k] = int'(srcData[k*W +: W]);
        sentQ[k].push_back(passAll(val[k]));
      end
      if (dr[k] && occ[SLOTS+k] == 2) begin
        nOcc[SLOTS+k] = 0;
        if (sentQ[k].size() == 0) checkEq("R9", "unexpected result", int'(dstData[k*W +: W]), -1);
        else checkEq("R9", "port order", int'(dstData[k*W +: W]), sentQ[k].pop_front());
      end
    end
    if (found) begin nOcc[w] = 0; nOcc[w+NP] = 1; end
    if (retValid) begin nOcc[int'(retTag)+NP] = 2; val[int'(retTag)+NP] = int'(retData); end
    occ = nOcc;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; srcValid = '0; srcData = '0; dstReady = '0;
    retValid = 1'b0; retTag = '0; retData = '0;
    for (int c = 0; c < CELLS; c++) begin occ[c] = 0; val[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    for (int k = 0; k < NP; k++) begin
      checkEq("R1", "srcReady in reset", int'(srcReady[k]), 1);
      checkEq("R1", "dstValid in reset", int'(dstValid[k]), 0);
    end
    checkEq("R1", "issueValid in reset", int'(issueValid), 0);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R1", "issueValid after reset", int'(issueValid), 0);

    // full-rate sources, always-ready sinks
    repeat (200) step('1, '1);
    // random traffic on both sides
    repeat (600) step(NP'($urandom), NP'($urandom));
    // single port streaming while others idle
    repeat (100) step(NP'(1 << 2), '1);
    // every destination stalled: chain must fill and issue must stop (R6)
    repeat (100) step('1, '0);
    checkEq("R6", "issueValid with all sinks stalled", int'(issueValid), 0);
    checkEq("R6", "srcReady with chain full", int'(srcReady), 0);
    // drain
    repeat (200) step('0, '1);
    for (int k = 0; k < NP; k++)
      checkEq("R9", "results left undelivered", sentQ[k].size(), 0);
    checkEq("R8", "items left in pipeline", pipeQ.size(), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule